// File: doc/BRIEF.md
# 64b/66b Transmit Gearbox

This block takes 66-bit line-code blocks, each made of a 2-bit sync header and 64 payload bits, and repacks them into an unbroken stream of fixed-width words for a serializer. The user side presents one payload word per cycle. The header travels with the first word of each block. The output side emits one word of the same width every cycle. A block is 66 bits long and a word is a power of two, so the two header bits of every block push later bits along. As a result, blocks straddle word boundaries. After 32 input words the held bits fill a whole output word. The input is then skipped for one cycle so that the extra bits can drain.

The word width is fixed at build time to 16 or 32 bits. The sequencing mode is set by a pin that stays static between resets. In external mode, user logic supplies the position within the 33-cycle pattern on every cycle. In internal mode, a built-in counter tracks the position and raises a pause flag one cycle before each skipped slot.

Top module: `gearbox_tx6466`

## Requirements
- R1: After reset the position is 0. The first output word starts with the first block's header, header bit 1 in tx_o bit W-1 and header bit 0 in bit W-2, followed by payload bits 63 downward.
- R2: Output bit W-1 is sent first. A block is sent as header bit 1, header bit 0, then payload bits 63 down to 0. Input word j of a block (j = 0 first) carries payload bits [63-jW -: W]. The output word for the input sampled at a clock edge appears at that edge. Every block leaves intact and in order.
- R3: A word can carry the tail of one block together with the head of the next. At position 64/W the output word is payload bits [1:0] of the previous block, then the new header, then the top W-4 payload bits of the new block.
- R4: The position runs 0..32 and then wraps. Positions that are a multiple of 64/W and below 32 start a block. Each 33-cycle period therefore takes in exactly 32/(64/W) complete blocks.
- R5: At position 32, hdr_i and data_i are ignored. The output word is the last W payload bits of the block just finished, and no bits stay held afterwards.
- R6: hdr_i is sampled only at a block-start position and has no effect on the continuation words.
- R7: In internal mode, pause_o is high for exactly one cycle, the cycle at position 31 just before each skipped slot, and low at all other positions.
- R8: In external mode, the position is taken from seq_i each cycle and pause_o stays low.
- R9: While reset is asserted, tx_o and pause_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the external position source, 0 the internal counter |
| seq_i | input | 6 | Position 0..32 supplied by user logic in external mode |
| hdr_i | input | 2 | Sync header, sampled at block-start positions |
| data_i | input | DATA_W | Payload word, most significant bit first on the line |
| tx_o | output | DATA_W | Output word for the serializer, bit DATA_W-1 sent first |
| pause_o | output | 1 | Internal mode: the next cycle's input will be skipped |

## Verification
The hardest case to reach is the cycle just before a skipped slot. At that point the held bits equal a full word, and any error in the occupancy arithmetic shows up only as a misplaced bit many blocks later. The bench drives several whole 33-cycle periods in both widths and both modes. It places random junk on the header pins during continuation words and on all inputs during skipped slots. It then rebuilds each 66-bit block from the serial bit order of the output. Because of this, a single shifted bit anywhere in a period corrupts a block comparison.

// File: rtl/tgb_pkg.sv
package tgb_pkg;

    localparam int BLK_DATA_W = 64;
    localparam int SYNC_W     = 2;
    localparam int SEQ_LAST   = 32;
    localparam int SEQ_W      = 6;

    typedef logic [SEQ_W-1:0] seq_t;

    // Bits left over from earlier words when the word at this position begins.
    function automatic int held_bits(input seq_t pos, input int words_per_blk);
        return SYNC_W * ((int'(pos) + words_per_blk - 1) / words_per_blk);
    endfunction

    function automatic logic is_blk_start(input seq_t pos, input int words_per_blk);
        return ((int'(pos) % words_per_blk) == 0) && (int'(pos) != SEQ_LAST);
    endfunction

endpackage

// File: rtl/tgb_seq.sv
module tgb_seq
    import tgb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode_i,
    input  seq_t seq_i,
    output seq_t pos_o,
    output logic pause_o
);

    typedef struct packed {
        seq_t cnt;
        logic pause;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = (st_q.cnt == seq_t'(SEQ_LAST)) ? '0 : st_q.cnt + 1'b1;
        st_d.pause = !ext_mode_i && (st_d.cnt == seq_t'(SEQ_LAST - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o   = ext_mode_i ? seq_i : st_q.cnt;
    assign pause_o = st_q.pause;

endmodule

// File: rtl/tgb_pack.sv
module tgb_pack
    import tgb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_t              pos_i,
    input  logic [1:0]        hdr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o,
    output logic [DATA_W-1:0] held_o
);

    localparam int WPB   = BLK_DATA_W / DATA_W;
    localparam int CAT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] held;
        logic [DATA_W-1:0] word;
    } pack_state_t;

    pack_state_t st_d, st_q;

    always_comb begin
        int               have;
        int               fresh;
        int               spill;
        logic [CAT_W-1:0] cat;
        st_d  = st_q;
        have  = held_bits(pos_i, WPB);
        fresh = 0;
        spill = 0;
        cat   = '0;
        if (pos_i == seq_t'(SEQ_LAST)) begin
            // held register is exactly one word here: drain it
            st_d.word = st_q.held;
            st_d.held = '0;
        end else begin
            if (is_blk_start(pos_i, WPB)) begin
                fresh = DATA_W + SYNC_W;
                cat   = {{(DATA_W - SYNC_W){1'b0}}, hdr_i, data_i};
            end else begin
                fresh = DATA_W;
                cat   = {{DATA_W{1'b0}}, data_i};
            end
            cat   = cat | ({{DATA_W{1'b0}}, st_q.held} << fresh);
            spill = have + fresh - DATA_W;
            for (int i = 0; i < DATA_W; i++) begin
                st_d.word[i] = cat[i + spill];
                st_d.held[i] = (i < spill) ? cat[i] : 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign held_o = st_q.held;

endmodule

// File: rtl/gearbox_tx6466.sv
module gearbox_tx6466
    import tgb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic [1:0]        hdr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] tx_o,
    output logic              pause_o
);

    seq_t              pos;
    logic [DATA_W-1:0] held;

    tgb_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode_i(ext_mode_i),
        .seq_i     (seq_i),
        .pos_o     (pos),
        .pause_o   (pause_o)
    );

    tgb_pack #(
        .DATA_W(DATA_W)
    ) i_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (pos),
        .hdr_i (hdr_i),
        .data_i(data_i),
        .word_o(tx_o),
        .held_o(held)
    );

endmodule

// File: rtl/tgb_chk.sv
module tgb_chk
    import tgb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode_i,
    input seq_t              pos_i,
    input logic              pause_o,
    input logic [DATA_W-1:0] held_i
);

    AST_PAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |=> !pause_o) else $error("pause longer than one cycle"); // R7

    AST_PAUSE_LEADS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |=> (pos_i == seq_t'(SEQ_LAST))) else $error("pause not followed by skip slot"); // R7

    AST_STALL_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && $past(!ext_mode_i) && pos_i == seq_t'(SEQ_LAST)) |-> $past(pause_o))
        else $error("skip slot without pause"); // R7

    AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i == seq_t'(SEQ_LAST)) |=> (held_i == '0)) else $error("bits held after skip slot"); // R5

    AST_EXT_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode_i && $past(ext_mode_i)) |-> !pause_o) else $error("pause in external mode"); // R8

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |-> (pos_i <= seq_t'(SEQ_LAST))) else $error("position out of range"); // R4

endmodule

bind gearbox_tx6466 tgb_chk #(
    .DATA_W(DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_mode_i(ext_mode_i),
    .pos_i     (pos),
    .pause_o   (pause_o),
    .held_i    (held)
);

// File: tb/test_gearbox_tx6466.sv
`timescale 1ns/1ps
module test_gearbox_tx6466;

    localparam int NPER = 4;
    localparam int NCYC = 33 * NPER;
    localparam int NB   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [5:0]  seq = '0;
    logic [1:0]  h16 = '0, h32 = '0;
    logic [15:0] d16 = '0;
    logic [31:0] d32 = '0;
    logic [15:0] tx16;
    logic [31:0] tx32;
    logic        p16, p32;

    logic [1:0]   hmem [2][NB];
    logic [63:0]  pmem [2][NB];
    logic [127:0] rxbuf [2];
    int           rxcnt [2];
    int           rb [2];
    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    gearbox_tx6466 #(.DATA_W(16)) i_gearbox_tx6466 (
        .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .seq_i(seq),
        .hdr_i(h16), .data_i(d16), .tx_o(tx16), .pause_o(p16));

    gearbox_tx6466 #(.DATA_W(32)) i_gearbox_tx6466_w32 (
        .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .seq_i(seq),
        .hdr_i(h32), .data_i(d32), .tx_o(tx32), .pause_o(p32));

    task automatic chk(input string req, input logic [65:0] got, input logic [65:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic fill(input int pat);
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < NB; i++) begin
                if (pat == 0) begin
                    pmem[w][i] = {$urandom, $urandom};
                    hmem[w][i] = 2'($urandom);
                end else begin
                    pmem[w][i] = (64'h1 << (i % 64)) ^ {64{i[0]}};
                    hmem[w][i] = i[0] ? 2'b10 : 2'b01;
                end
            end
        end
    endtask

    task automatic step(input int k, input bit ext);
        int pos;
        pos = k % 33;
        // R7 / R8: pause visible in the cycle before the skipped slot
        chk(ext ? "R8 pause16" : "R7 pause16", 66'(p16), 66'(!ext && pos == 31));
        chk(ext ? "R8 pause32" : "R7 pause32", 66'(p32), 66'(!ext && pos == 31));
        seq = 6'(pos);
        for (int w = 0; w < 2; w++) begin
            int ww, wpb, bpp, blk, j;
            logic [31:0] word;
            logic [1:0]  h;
            ww   = w ? 32 : 16;
            wpb  = 64 / ww;
            bpp  = 32 / wpb;
            word = $urandom;
            h    = 2'($urandom);
            if (pos != 32) begin
                blk = (k / 33) * bpp + pos / wpb;
                j   = pos % wpb;
                for (int b = 0; b < ww; b++) word[ww-1-b] = pmem[w][blk][63 - j*ww - b];
                if (j == 0) h = hmem[w][blk];
            end
            if (w == 0) begin
                d16 = word[15:0];
                h16 = h;
            end else begin
                d32 = word;
                h32 = h;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            int ww, bpp;
            logic [31:0] word;
            ww   = w ? 32 : 16;
            bpp  = w ? 16 : 8;
            word = w ? tx32 : {16'h0, tx16};
            for (int b = 0; b < ww; b++) begin
                rxbuf[w] = {rxbuf[w][126:0], word[ww-1-b]};
                rxcnt[w]++;
                if (rxcnt[w] == 66) begin
                    rxcnt[w] = 0;
                    chk("R2/R6 block rebuilt", rxbuf[w][65:0], {hmem[w][rb[w]], pmem[w][rb[w]]});
                    rb[w]++;
                end
            end
            if (pos == 32) begin
                int last;
                last = (k / 33 + 1) * bpp - 1;
                chk("R5 skip-slot word", 66'(word), 66'(pmem[w][last] & ((64'h1 << ww) - 1)));
                chk("R4 blocks per period", 66'(rb[w]), 66'((k / 33 + 1) * bpp));
            end
        end
        if (k == 0) begin
            chk("R1 first word w16", 66'(tx16), 66'({hmem[0][0], pmem[0][0][63:50]}));
            chk("R1 first word w32", 66'(tx32), 66'({hmem[1][0], pmem[1][0][63:34]}));
        end
        if (k == 2)
            chk("R3 straddle w32", 66'(tx32), 66'({pmem[1][0][1:0], hmem[1][1], pmem[1][1][63:36]}));
        if (k == 4)
            chk("R3 straddle w16", 66'(tx16), 66'({pmem[0][0][1:0], hmem[0][1], pmem[0][1][63:52]}));
    endtask

    task automatic run_phase(input bit ext, input int pat);
        @(negedge clk);
        rst_n    = 1'b0;
        ext_mode = ext;
        fill(pat);
        for (int w = 0; w < 2; w++) begin
            rxbuf[w] = '0;
            rxcnt[w] = 0;
            rb[w]    = 0;
        end
        repeat (3) @(negedge clk);
        chk("R9 reset tx16", 66'(tx16), 66'(0));
        chk("R9 reset tx32", 66'(tx32), 66'(0));
        chk("R9 reset pause", 66'({p16, p32}), 66'(0));
        rst_n = 1'b1;
        for (int k = 0; k < NCYC; k++) step(k, ext);
    endtask

    initial begin
        run_phase(1'b0, 0);
        run_phase(1'b1, 0);
        run_phase(1'b0, 1);
        run_phase(1'b1, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule